// File: doc/BRIEF.md
# System RAM Window Decoder

This block sits between an 8-bit CPU bus and two optional static RAM chips. It maps the CPU address window 0x1000 to 0x4FFF onto the two chips. Each chip may be missing, or it may hold 2 KB or 8 KB. A layout register that software writes sets how long each of the two consecutive regions in the window is. The size of the chip that is actually fitted does not affect the region lengths. For each access the block produces one chip select, a write enable and a chip-local address. It also returns read data to the CPU.

A region can be longer than its chip. In that case the chip-local address is folded by the fitted size, so the chip shows up repeated through the region. A read that no chip serves returns the open-bus value 0xFF, and a write in the same case goes nowhere. The layout register can also hand the whole window to a cartridge. In that mode neither RAM chip is selected.

Top module: `sysram_decoder`

## Requirements
- R1: After reset the layout register holds 0x00. Reading address 0x0110 returns 0x00, and the window decodes as two 8 KB regions.
- R2: A write strobe with address 0x0110 stores all eight data bits on that clock edge. A read of 0x0110 returns the stored value.
- R3: Bit 3 of the layout register sets the length of region 0, which starts at 0x1000. A 1 gives 0x0800 bytes and a 0 gives 0x2000 bytes. Region 0 drives chip select bit 0.
- R4: Bit 2 sets the length of region 1 with the same encoding. Region 1 begins at the first address after region 0 and drives chip select bit 1.
- R5: The chip-local address is the offset inside the region ANDed with (fitted size - 1). A 2 KB chip in an 8 KB region therefore repeats every 0x800 bytes. The size inputs are encoded per chip as 00 = absent, 01 = 2 KB, 10 = 8 KB, and 11 = absent.
- R6: An address outside both regions asserts no chip select. A read of such an address returns 0xFF, unless the address is 0x0110.
- R7: An access to a region whose chip is absent asserts no chip select. A read returns 0xFF and a write leaves the chip contents unchanged.
- R8: When bits 5 and 4 are both 1, neither chip select asserts anywhere, and window reads return 0xFF. Any other value of these bits decodes normally.
- R9: Bits 0, 1, 6 and 7 are stored and read back, but they have no effect on decoding.
- R10: At most one chip select is active. Chip selects need a read or write strobe, and a write enable only asserts during a write strobe.
- R11: A write to any address other than 0x0110 leaves the layout register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| chip_size | input | 2x2 | Fitted size code per chip (00 absent, 01 2 KB, 10 8 KB, 11 absent) |
| ram_rdata | input | 2x8 | Read data from each chip |
| ram_cs | output | 2 | Chip selects, one bit per chip |
| ram_we | output | 2 | Write enables, one bit per chip |
| ram_addr | output | 13 | Chip-local address |
| cpu_rdata | output | 8 | Read data to the CPU |

## Verification
The case that is hardest to reach from the ports is a write the decoder must drop: the write targets an absent chip or arrives while the cartridge owns the window. Nothing at the ports shows such a write directly. The bench first stores a known byte in the RAM model through a normal layout. It then sets up the dropping condition and issues the write. Finally it restores the normal layout or chip size and reads the location back through the CPU port to confirm the byte is unchanged. Mirroring is reached in a similar way. The bench fits a 2 KB chip under an 8 KB region and reads the byte back through an alias address 0x800 bytes above the one it was written at.

// File: rtl/sysram_dec_pkg.sv
package sysram_dec_pkg;
  localparam int NUM_CHIPS = 2;
  localparam int SIZE_W    = 2;
  localparam int OVL_LO    = 4;
  localparam int OVL_HI    = 5;

  typedef enum logic [SIZE_W-1:0] {
    CHIP_ABSENT = 2'b00,
    CHIP_SMALL  = 2'b01,
    CHIP_LARGE  = 2'b10,
    CHIP_RSVD   = 2'b11
  } chip_size_e;

  typedef struct packed {
    logic [NUM_CHIPS-1:0] small_region;
    logic                 overlay;
  } layout_t;

  // region i length is chosen by control bit (3 - i)
  function automatic int len_bit(input int idx);
    return 3 - idx;
  endfunction
endpackage

// File: rtl/sysram_rst_sync.sv
module sysram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/sysram_ctrl_reg.sv
module sysram_ctrl_reg
  import sysram_dec_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] CTRL_ADDR = 16'h0110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output layout_t           layout
);
  logic              ctrl_en;
  logic [DATA_W-1:0] ctrl_d;

  assign ctrl_en = wr && (addr == ADDR_W'(CTRL_ADDR));

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_en) begin
      ctrl_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  for (genvar i = 0; i < NUM_CHIPS; i++) begin : g_len
    assign layout.small_region[i] = ctrl_q[len_bit(i)];
  end

  assign layout.overlay = &ctrl_q[OVL_HI:OVL_LO];
endmodule

// File: rtl/sysram_region.sv
module sysram_region
  import sysram_dec_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SMALL_BYTES = 2048,
  parameter int LARGE_BYTES = 8192
) (
  input  layout_t                            layout,
  output logic [NUM_CHIPS-1:0][ADDR_W-1:0]   region_lo,
  output logic [NUM_CHIPS-1:0][ADDR_W-1:0]   region_len
);
  localparam logic [ADDR_W-1:0] SMALL_LEN = ADDR_W'(SMALL_BYTES);
  localparam logic [ADDR_W-1:0] LARGE_LEN = ADDR_W'(LARGE_BYTES);

  for (genvar i = 0; i < NUM_CHIPS; i++) begin : g_reg
    assign region_len[i] = layout.small_region[i] ? SMALL_LEN : LARGE_LEN;
    if (i == 0) begin : g_first
      assign region_lo[i] = '0;
    end else begin : g_next
      assign region_lo[i] = region_lo[i-1] + region_len[i-1];
    end
  end
endmodule

// File: rtl/sysram_chip_port.sv
module sysram_chip_port
  import sysram_dec_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SMALL_BYTES = 2048,
  parameter int LARGE_BYTES = 8192,
  parameter int LOC_W       = 13
) (
  input  logic [ADDR_W-1:0] offset,
  input  logic              in_window,
  input  logic              overlay,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] len,
  input  logic [SIZE_W-1:0] size_code,
  output logic              sel,
  output logic [LOC_W-1:0]  local_addr
);
  logic              present;
  logic [LOC_W-1:0]  mask;
  logic [ADDR_W-1:0] rel;
  logic              in_region;

  always_comb begin
    present = 1'b0;
    mask    = '0;
    case (chip_size_e'(size_code))
      CHIP_SMALL: begin
        present = 1'b1;
        mask    = LOC_W'(SMALL_BYTES - 1);
      end
      CHIP_LARGE: begin
        present = 1'b1;
        mask    = LOC_W'(LARGE_BYTES - 1);
      end
      default: begin
        present = 1'b0;
        mask    = '0;
      end
    endcase
  end

  assign rel        = offset - lo;
  assign in_region  = (offset >= lo) && (rel < len);
  assign sel        = in_window && !overlay && present && in_region;
  assign local_addr = rel[LOC_W-1:0] & mask;
endmodule

// File: rtl/sysram_decoder.sv
module sysram_decoder
  import sysram_dec_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 8,
  parameter logic [15:0] CTRL_ADDR   = 16'h0110,
  parameter logic [15:0] WIN_BASE    = 16'h1000,
  parameter int          SMALL_BYTES = 2048,
  parameter int          LARGE_BYTES = 8192,
  parameter int          LOC_W       = $clog2(LARGE_BYTES)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [ADDR_W-1:0]                   cpu_addr,
  input  logic                                cpu_rd,
  input  logic                                cpu_wr,
  input  logic [DATA_W-1:0]                   cpu_wdata,
  input  logic [NUM_CHIPS-1:0][SIZE_W-1:0]    chip_size,
  input  logic [NUM_CHIPS-1:0][DATA_W-1:0]    ram_rdata,
  output logic [NUM_CHIPS-1:0]                ram_cs,
  output logic [NUM_CHIPS-1:0]                ram_we,
  output logic [LOC_W-1:0]                    ram_addr,
  output logic [DATA_W-1:0]                   cpu_rdata
);
  localparam logic [ADDR_W-1:0] BASE     = ADDR_W'(WIN_BASE);
  localparam int                WIN_SPAN = NUM_CHIPS * LARGE_BYTES;
  localparam logic [ADDR_W:0]   WIN_END  = (ADDR_W+1)'(WIN_BASE) + (ADDR_W+1)'(WIN_SPAN);
  localparam logic [DATA_W-1:0] OPEN_BUS = '1;

  logic                               rst_sync_n;
  logic [DATA_W-1:0]                  ctrl_q;
  layout_t                            layout;
  logic [NUM_CHIPS-1:0][ADDR_W-1:0]   region_lo;
  logic [NUM_CHIPS-1:0][ADDR_W-1:0]   region_len;
  logic [NUM_CHIPS-1:0]               sel;
  logic [NUM_CHIPS-1:0][LOC_W-1:0]    local_addr;
  logic [ADDR_W-1:0]                  offset;
  logic                               in_window;
  logic                               access;
  logic                               ctrl_hit;

  sysram_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sysram_ctrl_reg #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CTRL_ADDR (CTRL_ADDR)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .addr   (cpu_addr),
    .wr     (cpu_wr),
    .wdata  (cpu_wdata),
    .ctrl_q (ctrl_q),
    .layout (layout)
  );

  sysram_region #(
    .ADDR_W      (ADDR_W),
    .SMALL_BYTES (SMALL_BYTES),
    .LARGE_BYTES (LARGE_BYTES)
  ) u_region (
    .layout     (layout),
    .region_lo  (region_lo),
    .region_len (region_len)
  );

  assign in_window = ({1'b0, cpu_addr} >= {1'b0, BASE}) && ({1'b0, cpu_addr} < WIN_END);
  assign offset    = cpu_addr - BASE;
  assign access    = cpu_rd || cpu_wr;
  assign ctrl_hit  = (cpu_addr == ADDR_W'(CTRL_ADDR));

  for (genvar i = 0; i < NUM_CHIPS; i++) begin : g_chip
    sysram_chip_port #(
      .ADDR_W      (ADDR_W),
      .SMALL_BYTES (SMALL_BYTES),
      .LARGE_BYTES (LARGE_BYTES),
      .LOC_W       (LOC_W)
    ) u_port (
      .offset     (offset),
      .in_window  (in_window),
      .overlay    (layout.overlay),
      .lo         (region_lo[i]),
      .len        (region_len[i]),
      .size_code  (chip_size[i]),
      .sel        (sel[i]),
      .local_addr (local_addr[i])
    );

    assign ram_cs[i] = sel[i] && access;
    assign ram_we[i] = sel[i] && cpu_wr;
  end

  always_comb begin
    ram_addr = '0;
    for (int i = 0; i < NUM_CHIPS; i++) begin
      if (sel[i]) begin
        ram_addr = ram_addr | local_addr[i];
      end
    end
  end

  always_comb begin
    cpu_rdata = OPEN_BUS;
    if (ctrl_hit) begin
      cpu_rdata = ctrl_q;
    end else begin
      for (int i = 0; i < NUM_CHIPS; i++) begin
        if (sel[i]) begin
          cpu_rdata = ram_rdata[i];
        end
      end
    end
  end
endmodule

// File: rtl/sysram_decoder_chk.sv
module sysram_decoder_chk
  import sysram_dec_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int          LOC_W     = 13,
  parameter logic [15:0] CTRL_ADDR = 16'h0110,
  parameter logic [15:0] WIN_BASE  = 16'h1000,
  parameter int          SMALL_BYTES = 2048,
  parameter int          LARGE_BYTES = 8192
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [ADDR_W-1:0]                cpu_addr,
  input logic                             cpu_rd,
  input logic                             cpu_wr,
  input logic [DATA_W-1:0]                cpu_wdata,
  input logic [NUM_CHIPS-1:0][SIZE_W-1:0] chip_size,
  input logic [DATA_W-1:0]                ctrl,
  input logic [NUM_CHIPS-1:0]             ram_cs,
  input logic [NUM_CHIPS-1:0]             ram_we,
  input logic [LOC_W-1:0]                 ram_addr,
  input logic [DATA_W-1:0]                cpu_rdata
);
  localparam int WIN_TOP = int'(WIN_BASE) + NUM_CHIPS * LARGE_BYTES;
  logic ctrl_wr;
  logic outside;
  assign ctrl_wr = cpu_wr && (cpu_addr == ADDR_W'(CTRL_ADDR));
  assign outside = (int'(cpu_addr) < int'(WIN_BASE)) || (int'(cpu_addr) >= WIN_TOP);

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ram_cs)); // R10
  AST_WE_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (|ram_we) |-> cpu_wr); // R10
  AST_CS_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_rd || cpu_wr) |-> (ram_cs == '0)); // R10
  AST_REG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ctrl == $past(cpu_wdata))); // R2
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl)); // R11
  AST_OUTSIDE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    outside |-> (ram_cs == '0)); // R6
  AST_OPEN_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && (ram_cs == '0) && (cpu_addr != ADDR_W'(CTRL_ADDR))) |-> (cpu_rdata == '1)); // R6
  AST_CART_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (&ctrl[OVL_HI:OVL_LO]) |-> (ram_cs == '0)); // R8
  AST_ABSENT0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((chip_size[0] == CHIP_ABSENT) || (chip_size[0] == CHIP_RSVD)) |-> !ram_cs[0]); // R7
  AST_ABSENT1_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((chip_size[1] == CHIP_ABSENT) || (chip_size[1] == CHIP_RSVD)) |-> !ram_cs[1]); // R7
  AST_MIRROR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_cs[0] && (chip_size[0] == CHIP_SMALL)) |-> (int'(ram_addr) < SMALL_BYTES)); // R5
endmodule

bind sysram_decoder sysram_decoder_chk #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .LOC_W       (LOC_W),
  .CTRL_ADDR   (CTRL_ADDR),
  .WIN_BASE    (WIN_BASE),
  .SMALL_BYTES (SMALL_BYTES),
  .LARGE_BYTES (LARGE_BYTES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cpu_addr  (cpu_addr),
  .cpu_rd    (cpu_rd),
  .cpu_wr    (cpu_wr),
  .cpu_wdata (cpu_wdata),
  .chip_size (chip_size),
  .ctrl      (ctrl_q),
  .ram_cs    (ram_cs),
  .ram_we    (ram_we),
  .ram_addr  (ram_addr),
  .cpu_rdata (cpu_rdata)
);

// File: tb/sysram_decoder_test.sv
module sysram_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [15:0]      cpu_addr = '0;
  logic             cpu_rd = 1'b0;
  logic             cpu_wr = 1'b0;
  logic [7:0]       cpu_wdata = '0;
  logic [1:0][1:0]  chip_size = {2'b10, 2'b10};
  logic [1:0][7:0]  ram_rdata;
  logic [1:0]       ram_cs;
  logic [1:0]       ram_we;
  logic [12:0]      ram_addr;
  logic [7:0]       cpu_rdata;

  logic [7:0] mem0 [8192];
  logic [7:0] mem1 [8192];

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysram_decoder uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .chip_size (chip_size),
    .ram_rdata (ram_rdata),
    .ram_cs    (ram_cs),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .cpu_rdata (cpu_rdata)
  );

  assign ram_rdata[0] = mem0[ram_addr];
  assign ram_rdata[1] = mem1[ram_addr];

  always @(posedge clk) begin
    if (ram_we[0]) mem0[ram_addr] <= cpu_wdata;
    if (ram_we[1]) mem1[ram_addr] <= cpu_wdata;
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(posedge clk);
    #1 cpu_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #1 d = cpu_rdata;
    cpu_rd = 1'b0;
  endtask

  task automatic probe(input logic [15:0] a, input logic [1:0] exp_cs,
                       input logic [12:0] exp_loc, input string tag);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #1;
    chk(16'(ram_cs), 16'(exp_cs), {tag, " cs"});
    chk(16'(ram_we), 16'h0, "R10 no write enable on read");
    if (exp_cs != 2'b00) chk(16'(ram_addr), 16'(exp_loc), {tag, " local addr"});
    else                 chk(16'(cpu_rdata), 16'h00FF, {tag, " open bus"});
    cpu_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    bus_read(16'h0110, d);
    chk(16'(d), 16'h0000, "R1 register after reset");
    probe(16'h3000, 2'b10, 13'h0000, "R1 default 8K/8K layout");
    @(negedge clk);
    #1 chk(16'(ram_cs), 16'h0, "R10 no cs without strobe");
  endtask

  task automatic t_readback();
    logic [7:0] d;
    bus_write(16'h0110, 8'hA5);
    bus_read(16'h0110, d);
    chk(16'(d), 16'h00A5, "R2 readback");
    bus_write(16'h0111, 8'hFF);
    bus_read(16'h0110, d);
    chk(16'(d), 16'h00A5, "R11 other address write ignored");
    bus_write(16'h0110, 8'h00);
  endtask

  task automatic t_layouts();
    logic [7:0] d;
    bus_write(16'h0110, 8'h00);
    probe(16'h0FFF, 2'b00, 13'h0, "R6 below window");
    probe(16'h1000, 2'b01, 13'h0000, "R3 layout00 start");
    probe(16'h2FFF, 2'b01, 13'h1FFF, "R3 layout00 end r0");
    probe(16'h3000, 2'b10, 13'h0000, "R4 layout00 start r1");
    probe(16'h4FFF, 2'b10, 13'h1FFF, "R4 layout00 end r1");
    probe(16'h5000, 2'b00, 13'h0, "R6 above window");
    bus_write(16'h4FFF, 8'hC1);
    bus_read(16'h4FFF, d);
    chk(16'(d), 16'h00C1, "R4 chip1 data path");
    bus_write(16'h0110, 8'h04);
    probe(16'h2FFF, 2'b01, 13'h1FFF, "R3 layout01 end r0");
    probe(16'h37FF, 2'b10, 13'h07FF, "R4 layout01 end r1");
    probe(16'h3800, 2'b00, 13'h0, "R6 layout01 past r1");
    bus_write(16'h0110, 8'h08);
    probe(16'h17FF, 2'b01, 13'h07FF, "R3 layout10 end r0");
    probe(16'h1800, 2'b10, 13'h0000, "R4 layout10 start r1");
    probe(16'h37FF, 2'b10, 13'h1FFF, "R4 layout10 end r1");
    probe(16'h3800, 2'b00, 13'h0, "R6 layout10 past r1");
    bus_write(16'h0110, 8'h0C);
    probe(16'h17FF, 2'b01, 13'h07FF, "R3 layout11 end r0");
    probe(16'h1FFF, 2'b10, 13'h07FF, "R4 layout11 end r1");
    probe(16'h2000, 2'b00, 13'h0, "R6 layout11 past r1");
    bus_write(16'h0110, 8'h00);
  endtask

  task automatic t_absent();
    logic [7:0] d;
    chip_size[0] = 2'b00;
    bus_write(16'h1234, 8'h99);
    probe(16'h1234, 2'b00, 13'h0, "R7 absent chip0");
    bus_read(16'h1234, d);
    chk(16'(d), 16'h00FF, "R7 absent read");
    probe(16'h3000, 2'b10, 13'h0000, "R7 chip1 unaffected");
    chip_size[0] = 2'b10;
    bus_read(16'h1234, d);
    chk(16'(d), 16'h0000, "R7 write to absent ignored");
    chip_size[1] = 2'b11;
    probe(16'h3000, 2'b00, 13'h0, "R5 code 11 absent");
    chip_size[1] = 2'b10;
  endtask

  task automatic t_mirror();
    logic [7:0] d;
    chip_size = {2'b01, 2'b01};
    bus_write(16'h1005, 8'h11);
    bus_read(16'h1805, d);
    chk(16'(d), 16'h0011, "R5 chip0 alias read");
    probe(16'h2805, 2'b01, 13'h0005, "R5 chip0 fold");
    bus_write(16'h3010, 8'h22);
    bus_read(16'h4810, d);
    chk(16'(d), 16'h0022, "R5 chip1 alias read");
    chip_size = {2'b10, 2'b10};
  endtask

  task automatic t_overlay();
    logic [7:0] d;
    bus_write(16'h1000, 8'h5A);
    bus_write(16'h0110, 8'h30);
    probe(16'h1000, 2'b00, 13'h0, "R8 overlay r0");
    probe(16'h3000, 2'b00, 13'h0, "R8 overlay r1");
    @(negedge clk);
    cpu_addr = 16'h1000; cpu_wdata = 8'h77; cpu_wr = 1'b1;
    #1 chk(16'(ram_we), 16'h0, "R8 overlay no write enable");
    @(posedge clk);
    #1 cpu_wr = 1'b0;
    bus_write(16'h0110, 8'h10);
    probe(16'h1000, 2'b01, 13'h0000, "R8 single bit decodes normally");
    bus_write(16'h0110, 8'h00);
    bus_read(16'h1000, d);
    chk(16'(d), 16'h005A, "R8 overlay write dropped");
  endtask

  task automatic t_unused_bits();
    logic [7:0] d;
    bus_write(16'h0110, 8'hC3);
    bus_read(16'h0110, d);
    chk(16'(d), 16'h00C3, "R9 unused bits stored");
    probe(16'h2FFF, 2'b01, 13'h1FFF, "R9 r0 still 8K");
    probe(16'h4FFF, 2'b10, 13'h1FFF, "R9 r1 still 8K");
    @(negedge clk);
    cpu_addr = 16'h3000; cpu_wdata = 8'h00; cpu_wr = 1'b1;
    #1 chk(16'(ram_we), 16'h2, "R10 write enable on chip1");
    cpu_wr = 1'b0;
    bus_write(16'h0110, 8'h00);
  endtask

  initial begin
    for (int i = 0; i < 8192; i++) begin
      mem0[i] = 8'h00;
      mem1[i] = 8'h00;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_readback();
    t_layouts();
    t_absent();
    t_mirror();
    t_overlay();
    t_unused_bits();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule